// File: doc/BRIEF.md
# Power Mode and Wake Controller

This block tracks the power-managed state of a small processor core. It has two run states, one on the primary oscillator and one on the internal RC oscillator. It has two idle states in which only the peripherals keep their clock, and one sleep state in which both the CPU clock and the peripheral clock stop. The core signals a sleep instruction with a one-cycle strobe. An idle-enable bit and a clock-select field then pick which low-power state is entered.

Wake sources are enabled interrupt flags and the watchdog timeout. An asynchronous reset also forces an exit. The block chooses the clock to resume on. It decides whether the primary oscillator needs a start-up delay before the CPU may run. It tells the core whether to branch to the interrupt vector. It also issues watchdog clear pulses, and it issues a watchdog reset pulse when a timeout arrives while code is running.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While and after reset (rst_n low), `mode` reads 1 (run on RC), `osc_run_sts` and `pri_osc_en` are 0, and both clock enables are 1. An asynchronous reset taken from any state forces the block back onto RC run.
- R2: In a run mode (`mode` 0 or 1), a `sleep_op` with `idle_en`=0 enters sleep (`mode`=4). In sleep, `cpu_clk_en`, `per_clk_en` and `pri_osc_en` are 0 and `osc_run_sts` is cleared.
- R3: A `sleep_op` with `idle_en`=1 enters an idle state, in which `cpu_clk_en`=0 and `per_clk_en`=1. From primary run (`mode` 0) with nonzero `clk_sel` it enters primary idle (`mode`=2), and the oscillator and `osc_run_sts` stay on. Otherwise it enters RC idle (`mode`=3), which turns the primary oscillator off and clears `osc_run_sts`.
- R4: Idle or sleep is left on the next edge when any bit of `irq_flag & irq_en` is set or `wdt_timeout` is high. A flag whose enable bit is 0 has no effect.
- R5: `vector_pulse` is high for exactly the one cycle after an interrupt wake, and only if `gie` was 1. A watchdog-only wake, or an interrupt wake with `gie`=0, gives no pulse.
- R6: A `wdt_timeout` in a run mode gives a one-cycle `wdt_rst_pulse` and a return to RC run with `osc_run_sts`=0. In idle or sleep it only wakes the block and gives no reset pulse.
- R7: `wdt_clr` pulses for one cycle after a `sleep_op` or `clrwdt_op` taken in a run mode, and after any cycle with `clk_fail` high.
- R8: A wake goes to RC run when `clk_sel`=0. It goes straight to primary run (`mode`=0, `osc_run_sts`=1, no `ost_start`) when waking from primary idle or when `pri_ext`=1.
- R9: Any other wake onto the primary clock enters the start-up wait (`mode`=5) with a one-cycle `ost_start`, `pri_osc_en`=1 and both clocks gated. `osc_ready` then moves the block to primary run with `osc_run_sts` set.
- R10: In sleep, `rc_osc_en` follows `wdt_fscm_en`.
- R11: In RC run, a nonzero `clk_sel` with `pri_ext`=0 turns on the primary oscillator and pulses `ost_start` while the CPU keeps running. `osc_ready` then switches to primary run with `osc_run_sts`=1. In primary run, `clk_sel`=0 returns to RC run and clears `osc_run_sts`.
- R12: A `sleep_op` outside the run modes is ignored: the state does not change and `wdt_clr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_op | input | 1 | Sleep instruction strobe |
| clrwdt_op | input | 1 | Clear-watchdog instruction strobe |
| idle_en | input | 1 | Sleep instruction enters idle instead of sleep |
| clk_sel | input | SEL_W | Clock select, 0 = internal RC, nonzero = primary |
| pri_ext | input | 1 | Primary source is an external clock needing no start-up delay |
| irq_flag | input | NUM_IRQ | Interrupt flags |
| irq_en | input | NUM_IRQ | Interrupt enables |
| gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog timeout |
| clk_fail | input | 1 | Loss of the selected clock source |
| osc_ready | input | 1 | Start-up timer expired |
| wdt_fscm_en | input | 1 | Watchdog or fail-safe monitor enabled |
| mode | output | 3 | 0 pri run, 1 RC run, 2 pri idle, 3 RC idle, 4 sleep, 5 start-up wait |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Peripheral clock gate |
| pri_osc_en | output | 1 | Primary oscillator enable |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| ost_start | output | 1 | Start-up timer request pulse |
| osc_run_sts | output | 1 | Primary oscillator running status |
| vector_pulse | output | 1 | Branch-to-vector strobe |
| wdt_rst_pulse | output | 1 | Watchdog reset strobe |
| wdt_clr | output | 1 | Watchdog and postscaler clear pulse |

## Verification
The bench builds the block with NUM_IRQ=4 and SEL_W=2, and enables only the three low flags. The fourth flag is raised with its enable bit cleared, which shows that a masked source cannot wake the block. Four flags are enough to tell apart wakes from different sources, with and without the global enable. With the two-bit select, every nonzero code means the primary clock, so entering primary idle, skipping the start-up delay and running the start-up wait can all be reached from a short chain of vectors.

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_op,
  input  logic               clrwdt_op,
  input  logic               idle_en,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               pri_ext,
  input  logic [NUM_IRQ-1:0] irq_flag,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               gie,
  input  logic               wdt_timeout,
  input  logic               clk_fail,
  input  logic               osc_ready,
  input  logic               wdt_fscm_en,
  output logic [2:0]         mode,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               pri_osc_en,
  output logic               rc_osc_en,
  output logic               ost_start,
  output logic               osc_run_sts,
  output logic               vector_pulse,
  output logic               wdt_rst_pulse,
  output logic               wdt_clr
);
  typedef enum logic [2:0] {
    M_RUN_PRI  = 3'd0,
    M_RUN_RC   = 3'd1,
    M_IDLE_PRI = 3'd2,
    M_IDLE_RC  = 3'd3,
    M_SLEEP    = 3'd4,
    M_OST_WAIT = 3'd5
  } mode_e;

  mode_e st, st_n;
  logic  sts_q, sts_n, pend_q, pend_n;
  logic  ost_n, vec_n, wrst_n, wclr_n;

  wire irq_hit = |(irq_flag & irq_en);
  wire pri_sel = |clk_sel;
  wire in_run  = (st == M_RUN_PRI) || (st == M_RUN_RC);
  wire in_idle = (st == M_IDLE_PRI) || (st == M_IDLE_RC);

  always_comb begin
    st_n   = st;
    sts_n  = sts_q;
    pend_n = pend_q;
    ost_n  = 1'b0;
    vec_n  = 1'b0;
    wrst_n = 1'b0;
    wclr_n = clk_fail | (in_run & (sleep_op | clrwdt_op));
    case (st)
      M_RUN_PRI, M_RUN_RC: begin
        if (wdt_timeout) begin
          st_n   = M_RUN_RC;
          sts_n  = 1'b0;
          pend_n = 1'b0;
          wrst_n = 1'b1;
        end else if (sleep_op) begin
          pend_n = 1'b0;
          if (!idle_en) begin
            st_n  = M_SLEEP;
            sts_n = 1'b0;
          end else if (pri_sel && st == M_RUN_PRI) begin
            st_n = M_IDLE_PRI;
          end else begin
            st_n  = M_IDLE_RC;
            sts_n = 1'b0;
          end
        end else if (st == M_RUN_PRI) begin
          if (!pri_sel) begin
            st_n  = M_RUN_RC;
            sts_n = 1'b0;
          end
        end else if (!pri_sel) begin
          pend_n = 1'b0;
        end else if (pri_ext || (pend_q && osc_ready)) begin
          st_n   = M_RUN_PRI;
          sts_n  = 1'b1;
          pend_n = 1'b0;
        end else if (!pend_q) begin
          pend_n = 1'b1;
          ost_n  = 1'b1;
        end
      end
      M_IDLE_PRI, M_IDLE_RC, M_SLEEP: begin
        if (irq_hit || wdt_timeout) begin
          vec_n = irq_hit & gie;
          if (!pri_sel) begin
            st_n  = M_RUN_RC;
            sts_n = 1'b0;
          end else if (st == M_IDLE_PRI || pri_ext) begin
            st_n  = M_RUN_PRI;
            sts_n = 1'b1;
          end else begin
            st_n  = M_OST_WAIT;
            ost_n = 1'b1;
          end
        end
      end
      M_OST_WAIT: begin
        if (osc_ready) begin
          st_n  = M_RUN_PRI;
          sts_n = 1'b1;
        end
      end
      default: st_n = M_RUN_RC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= M_RUN_RC;
      sts_q         <= 1'b0;
      pend_q        <= 1'b0;
      ost_start     <= 1'b0;
      vector_pulse  <= 1'b0;
      wdt_rst_pulse <= 1'b0;
      wdt_clr       <= 1'b0;
    end else begin
      st            <= st_n;
      sts_q         <= sts_n;
      pend_q        <= pend_n;
      ost_start     <= ost_n;
      vector_pulse  <= vec_n;
      wdt_rst_pulse <= wrst_n;
      wdt_clr       <= wclr_n;
    end
  end

  assign mode        = st;
  assign osc_run_sts = sts_q;
  assign cpu_clk_en  = in_run;
  assign per_clk_en  = in_run | in_idle;
  assign pri_osc_en  = (st == M_RUN_PRI) || (st == M_IDLE_PRI) || (st == M_OST_WAIT) ||
                       ((st == M_RUN_RC) && pend_q);
  assign rc_osc_en   = (st == M_RUN_RC) || (st == M_IDLE_RC) || wdt_fscm_en;
endmodule

module pwr_wake_ctrl_chk #(
  parameter int NUM_IRQ = 8,
  parameter int SEL_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sleep_op,
  input logic               clrwdt_op,
  input logic               idle_en,
  input logic [SEL_W-1:0]   clk_sel,
  input logic [NUM_IRQ-1:0] irq_flag,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               gie,
  input logic               wdt_timeout,
  input logic               osc_ready,
  input logic [2:0]         mode,
  input logic               cpu_clk_en,
  input logic               pri_osc_en,
  input logic               osc_run_sts,
  input logic               vector_pulse,
  input logic               wdt_rst_pulse,
  input logic               wdt_clr
);
  assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && sleep_op && !idle_en && !wdt_timeout) |=> (mode == 3'd4 && !pri_osc_en && !osc_run_sts));

  assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !(|(irq_flag & irq_en)) && !wdt_timeout) |=> mode == 3'd4);

  assert_vector_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vector_pulse |-> ($past(gie) && $past(|(irq_flag & irq_en)) && !$past(cpu_clk_en)));

  assert_wdt_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_pulse |-> ($past(cpu_clk_en) && mode == 3'd1 && !osc_run_sts));

  assert_wdt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && clrwdt_op) |=> wdt_clr);

  assert_ost_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 && osc_ready) |=> (mode == 3'd0 && osc_run_sts));

  assert_sleep_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && sleep_op && !clrwdt_op && !wdt_timeout && !(|(irq_flag & irq_en)) && mode != 3'd5)
      |=> $stable(mode));
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op), .clrwdt_op(clrwdt_op),
  .idle_en(idle_en), .clk_sel(clk_sel), .irq_flag(irq_flag), .irq_en(irq_en),
  .gie(gie), .wdt_timeout(wdt_timeout), .osc_ready(osc_ready), .mode(mode),
  .cpu_clk_en(cpu_clk_en), .pri_osc_en(pri_osc_en), .osc_run_sts(osc_run_sts),
  .vector_pulse(vector_pulse), .wdt_rst_pulse(wdt_rst_pulse), .wdt_clr(wdt_clr)
);

// File: tb/pwr_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_wake_ctrl_tb_top;
  localparam int NI = 4;
  localparam int SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_op = 0, clrwdt_op = 0, idle_en = 0, pri_ext = 0, gie = 0;
  logic wdt_timeout = 0, clk_fail = 0, osc_ready = 0, wdt_fscm_en = 0;
  logic [SW-1:0] clk_sel = '0;
  logic [NI-1:0] irq_flag = '0, irq_en = 4'b0111;
  logic [2:0] mode;
  logic cpu_clk_en, per_clk_en, pri_osc_en, rc_osc_en, ost_start;
  logic osc_run_sts, vector_pulse, wdt_rst_pulse, wdt_clr;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_wake_ctrl #(.NUM_IRQ(NI), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op), .clrwdt_op(clrwdt_op),
    .idle_en(idle_en), .clk_sel(clk_sel), .pri_ext(pri_ext), .irq_flag(irq_flag),
    .irq_en(irq_en), .gie(gie), .wdt_timeout(wdt_timeout), .clk_fail(clk_fail),
    .osc_ready(osc_ready), .wdt_fscm_en(wdt_fscm_en), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .pri_osc_en(pri_osc_en),
    .rc_osc_en(rc_osc_en), .ost_start(ost_start), .osc_run_sts(osc_run_sts),
    .vector_pulse(vector_pulse), .wdt_rst_pulse(wdt_rst_pulse), .wdt_clr(wdt_clr));

  typedef struct packed {
    logic [1:0] sel; logic idle; logic slp; logic [3:0] irq;
    logic wdt; logic rdy; logic ext; logic g;
    logic [2:0] m; logic sts; logic vec; logic wr; logic ost;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{2'd0,1'b0,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0}, // R2 sleep
    '{2'd0,1'b0,1'b0,4'b1000,1'b0,1'b0,1'b0,1'b1, 3'd4,1'b0,1'b0,1'b0,1'b0}, // R4 masked flag
    '{2'd0,1'b0,1'b0,4'b0001,1'b0,1'b0,1'b0,1'b1, 3'd1,1'b0,1'b1,1'b0,1'b0}, // R4 R5 irq wake
    '{2'd0,1'b1,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b0,1'b0,1'b0}, // R3 RC idle
    '{2'd0,1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,1'b1, 3'd1,1'b0,1'b0,1'b0,1'b0}, // R6 wdt wake
    '{2'd0,1'b0,1'b0,4'b0000,1'b1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b0}, // R6 wdt reset
    '{2'd1,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,1'b1}, // R11 start
    '{2'd1,1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b0}, // R11 ready
    '{2'd1,1'b1,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,1'b0}, // R3 pri idle
    '{2'd1,1'b0,1'b0,4'b0010,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b0}, // R8 R5 no ost
    '{2'd1,1'b0,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0}, // R2
    '{2'd1,1'b0,1'b0,4'b0100,1'b0,1'b0,1'b0,1'b1, 3'd5,1'b0,1'b1,1'b0,1'b1}, // R9 wait
    '{2'd1,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd5,1'b0,1'b0,1'b0,1'b0}, // R9 hold
    '{2'd1,1'b0,1'b0,4'b0000,1'b0,1'b1,1'b0,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b0}, // R9 ready
    '{2'd1,1'b0,1'b1,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b0}, // R2
    '{2'd1,1'b0,1'b0,4'b0000,1'b1,1'b0,1'b1,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b0}, // R8 ext
    '{2'd0,1'b0,1'b0,4'b0000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,1'b0}  // R11 back
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    sleep_op = 0; clrwdt_op = 0; irq_flag = '0; wdt_timeout = 0;
    osc_ready = 0; clk_fail = 0; pri_ext = 0; gie = 0; idle_en = 0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #10;
    check("R1 mode", mode, 1);
    check("R1 sts", osc_run_sts, 0);
    check("R1 pri", pri_osc_en, 0);
    check("R1 clocks", {cpu_clk_en, per_clk_en}, 3);
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clk_sel = TBL[i].sel; idle_en = TBL[i].idle; sleep_op = TBL[i].slp;
      irq_flag = TBL[i].irq; wdt_timeout = TBL[i].wdt; osc_ready = TBL[i].rdy;
      pri_ext = TBL[i].ext; gie = TBL[i].g;
      step();
      check($sformatf("vec%0d mode", i), mode, TBL[i].m);
      check($sformatf("vec%0d sts", i), osc_run_sts, TBL[i].sts);
      check($sformatf("vec%0d vector R5", i), vector_pulse, TBL[i].vec);
      check($sformatf("vec%0d wdt_rst R6", i), wdt_rst_pulse, TBL[i].wr);
      check($sformatf("vec%0d ost R9", i), ost_start, TBL[i].ost);
      if (TBL[i].m == 3'd5) check("R9 pri on", pri_osc_en, 1);
      if (TBL[i].m == 3'd5) check("R9 clocks gated", {cpu_clk_en, per_clk_en}, 0);
      if (i == 6) check("R11 cpu runs", cpu_clk_en, 1);
      if (i == 6) check("R11 pri on", pri_osc_en, 1);
    end
    idle_inputs();

    clrwdt_op = 1; step();
    check("R7 clrwdt", wdt_clr, 1);
    @(negedge clk); clrwdt_op = 0; step();
    check("R7 quiet", wdt_clr, 0);
    @(negedge clk); clk_fail = 1; step();
    check("R7 clk_fail", wdt_clr, 1);
    @(negedge clk); clk_fail = 0; sleep_op = 1; step();
    check("R7 sleep clr", wdt_clr, 1);
    check("R2 gates", {cpu_clk_en, per_clk_en, pri_osc_en}, 0);
    @(negedge clk); sleep_op = 0; wdt_fscm_en = 0; #1;
    check("R10 rc off", rc_osc_en, 0);
    wdt_fscm_en = 1; #1;
    check("R10 rc on", rc_osc_en, 1);
    step();
    @(negedge clk); sleep_op = 1; step();
    check("R12 mode", mode, 4);
    check("R12 no clr", wdt_clr, 0);
    @(negedge clk); sleep_op = 0; irq_flag = 4'b0001; step();
    check("R4 wake", mode, 1);
    @(negedge clk); irq_flag = 0; idle_en = 1; sleep_op = 1; step();
    check("R3 idle clocks", {cpu_clk_en, per_clk_en}, 1);
    @(negedge clk); sleep_op = 0; idle_en = 0; clk_sel = 2'd2; pri_ext = 1; irq_flag = 4'b0010; step();
    check("R8 ext wake", mode, 0);
    check("R8 ext sts", osc_run_sts, 1);
    @(negedge clk); irq_flag = 0; rst_n = 0; #1;
    check("R1 async mode", mode, 1);
    check("R1 async sts", osc_run_sts, 0);
    check("R1 async pri", pri_osc_en, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule